// File: doc/BRIEF.md
# Conflict Summary Table Unit

This unit keeps, for the thread running on the local processor, a record of which remote processors it has clashed with. There are three bit vectors with one bit per processor. The first marks peers whose writes overlapped the local reads (read-write). The second marks peers whose reads overlapped the local writes (write-read). The third marks peers whose writes overlapped the local writes (write-write).

Bits are set from two sources: the conflict type carried back on coherence responses, and local snoops that hit the thread's own access signatures. The tables only gather the result of conflict detection. They hold no addresses, so conflict tracking is kept apart from access tracking.

At commit the unit takes a snapshot of the union of the write-read and write-write tables. It then visits each marked peer in ascending index order. For each one it raises an abort request that asks the memory system to compare-and-swap that peer's transaction status word from active to aborted. Only one request is in flight at a time. Once the last request is acknowledged, the unit pulses a done signal, which lets the committing thread move on: it marks its own status word committed, and only after that does any physical commit of hardware state start. A clear input resets all three tables when a new transaction begins.

Top module: `xconf_table`

## Requirements
- R1: A coherence response with `resp_valid_i` high sets bit `resp_pid_i` in one table, chosen by `resp_kind_i`: 1 selects read-write (`rw_o`), 2 selects write-read (`wr_o`), 3 selects write-write (`ww_o`). The bit is visible on the cycle after the edge that sampled the response. Kind 0 changes nothing.
- R2: The snoop path (`snoop_valid_i`, `snoop_pid_i`, `snoop_kind_i`) uses the same kind encoding and the same timing. When a response and a snoop arrive in the same cycle, both take effect.
- R3: Once set, a table bit stays set until a clear. A set request that names the local processor (index `LOCAL_ID`, default 0) is ignored, so that bit is never set.
- R4: `clr_i` zeroes all three tables by the next cycle. It takes priority over any set requests sampled in the same cycle.
- R5: A commit (`commit_i` sampled while idle) issues one abort request on `cas_pid_o` for each peer set in `wr_o` or `ww_o` at that edge, in ascending index order. A peer set only in `rw_o` receives no request. The first request appears on the cycle after the commit.
- R6: At most one request is outstanding. `cas_req_o` and `cas_pid_o` hold steady until `cas_ack_i` is sampled high. The next peer's index appears on the cycle after that acknowledge.
- R7: A peer set in both `wr_o` and `ww_o` receives exactly one abort request.
- R8: `done_o` is a one-cycle pulse with `cas_req_o` low. It comes on the cycle after the last acknowledge, or on the cycle after the commit when no write-read or write-write bit is set.
- R9: A commit sampled while a walk is in progress is ignored. The walk leaves the tables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Zero all tables (transaction start) |
| resp_valid_i | input | 1 | Conflict type on coherence response is valid |
| resp_pid_i | input | PID_W (3) | Remote processor that sent the response |
| resp_kind_i | input | 2 | Conflict type: 0 none, 1 read-write, 2 write-read, 3 write-write |
| snoop_valid_i | input | 1 | Local snoop hit a signature |
| snoop_pid_i | input | PID_W (3) | Remote processor that issued the snooped request |
| snoop_kind_i | input | 2 | Conflict type, same encoding as `resp_kind_i` |
| rw_o | output | NPROC (8) | Read-write conflict table |
| wr_o | output | NPROC (8) | Write-read conflict table |
| ww_o | output | NPROC (8) | Write-write conflict table |
| commit_i | input | 1 | Start the commit-time abort walk |
| cas_req_o | output | 1 | Abort compare-and-swap request |
| cas_pid_o | output | PID_W (3) | Processor whose status word is to be swapped from active to aborted |
| cas_ack_i | input | 1 | Memory system finished the requested swap |
| done_o | output | 1 | Pulse: every abort is acknowledged, so the commit may proceed |

## Verification
Table updates show up exactly one edge after the request or clear is sampled. The bench therefore reads the tables one cycle after driving a stimulus, and before driving the next one.

The first abort request is due one cycle after the commit edge. Each later index is due one cycle after the acknowledge edge, and `done_o` is due one cycle after the final acknowledge or, for an empty walk, one cycle after the commit. The bench drives all inputs and samples all outputs 1 ns after each rising edge, so every check falls in the cycle where the result is first due.

Before acknowledging, the bench holds each request for a number of cycles that varies from peer to peer, which checks that the request stays stable. It also looks at the cycle after `done_o` to confirm that no second walk has started.

// File: rtl/xconf_pkg.sv
package xconf_pkg;

    // Conflict type carried by responses and snoops
    typedef enum logic [1:0] {
        CK_NONE = 2'd0,
        CK_RW   = 2'd1,
        CK_WR   = 2'd2,
        CK_WW   = 2'd3
    } conf_kind_e;

    // Number of conflict tables; table t holds kind t+1
    localparam int unsigned NUM_TBL = 3;

    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_WALK = 1'b1
    } walk_st_e;

endpackage

// File: rtl/xconf_tables.sv
module xconf_tables
    import xconf_pkg::*;
#(
    parameter int unsigned NPROC    = 8,
    parameter int unsigned LOCAL_ID = 0,
    localparam int unsigned PID_W   = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             resp_valid_i,
    input  logic [PID_W-1:0] resp_pid_i,
    input  logic [1:0]       resp_kind_i,
    input  logic             snoop_valid_i,
    input  logic [PID_W-1:0] snoop_pid_i,
    input  logic [1:0]       snoop_kind_i,
    output logic [NPROC-1:0] rw_o,
    output logic [NPROC-1:0] wr_o,
    output logic [NPROC-1:0] ww_o
);

    localparam logic [NPROC-1:0] LOCAL_MASK = NPROC'(1) << LOCAL_ID;

    typedef struct packed {
        logic [NUM_TBL-1:0][NPROC-1:0] tbl;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic [NUM_TBL-1:0][NPROC-1:0] set_vec;

    logic [NPROC-1:0] resp_hot;
    logic [NPROC-1:0] snoop_hot;

    assign resp_hot  = NPROC'(1) << resp_pid_i;
    assign snoop_hot = NPROC'(1) << snoop_pid_i;

    // One set vector per table, selected by kind code t+1
    for (genvar t = 0; t < NUM_TBL; t++) begin : g_set
        localparam logic [1:0] KCODE = 2'(t + 1);
        assign set_vec[t] =
            ((resp_valid_i  && (resp_kind_i  == KCODE)) ? resp_hot  : '0) |
            ((snoop_valid_i && (snoop_kind_i == KCODE)) ? snoop_hot : '0);
    end

    always_comb begin
        tbl_d = tbl_q;
        if (clr_i) begin
            tbl_d.tbl = '0;
        end else begin
            for (int t = 0; t < NUM_TBL; t++) begin
                tbl_d.tbl[t] = tbl_q.tbl[t] | (set_vec[t] & ~LOCAL_MASK);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rw_o = tbl_q.tbl[0];
    assign wr_o = tbl_q.tbl[1];
    assign ww_o = tbl_q.tbl[2];

endmodule

// File: rtl/xconf_pick.sv
module xconf_pick #(
    parameter int unsigned NPROC  = 8,
    localparam int unsigned PID_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic [NPROC-1:0] vec_i,
    output logic             found_o,
    output logic [PID_W-1:0] idx_o
);

    // Lowest set bit wins
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NPROC - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = PID_W'(i);
            end
        end
    end

endmodule

// File: rtl/xconf_walker.sv
module xconf_walker
    import xconf_pkg::*;
#(
    parameter int unsigned NPROC  = 8,
    localparam int unsigned PID_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             commit_i,
    input  logic [NPROC-1:0] abort_mask_i,
    input  logic             cas_ack_i,
    output logic             cas_req_o,
    output logic [PID_W-1:0] cas_pid_o,
    output logic             done_o,
    output logic             busy_o
);

    typedef struct packed {
        walk_st_e         st;
        logic [NPROC-1:0] pend;
    } walk_t;

    walk_t wk_d, wk_q;

    logic             pick_found;
    logic [PID_W-1:0] pick_idx;

    xconf_pick #(.NPROC(NPROC)) pick_i (
        .vec_i   (wk_q.pend),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    always_comb begin
        wk_d      = wk_q;
        cas_req_o = 1'b0;
        done_o    = 1'b0;
        unique case (wk_q.st)
            WK_IDLE: begin
                if (commit_i) begin
                    wk_d.st   = WK_WALK;
                    wk_d.pend = abort_mask_i;
                end
            end
            WK_WALK: begin
                if (!pick_found) begin
                    done_o  = 1'b1;
                    wk_d.st = WK_IDLE;
                end else begin
                    cas_req_o = 1'b1;
                    if (cas_ack_i) begin
                        wk_d.pend[pick_idx] = 1'b0;
                    end
                end
            end
            default: wk_d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wk_q <= '{st: WK_IDLE, pend: '0};
        end else begin
            wk_q <= wk_d;
        end
    end

    assign cas_pid_o = pick_idx;
    assign busy_o    = (wk_q.st == WK_WALK);

endmodule

// File: rtl/xconf_table.sv
module xconf_table
    import xconf_pkg::*;
#(
    parameter int unsigned NPROC    = 8,
    parameter int unsigned LOCAL_ID = 0,
    localparam int unsigned PID_W   = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             resp_valid_i,
    input  logic [PID_W-1:0] resp_pid_i,
    input  logic [1:0]       resp_kind_i,
    input  logic             snoop_valid_i,
    input  logic [PID_W-1:0] snoop_pid_i,
    input  logic [1:0]       snoop_kind_i,
    output logic [NPROC-1:0] rw_o,
    output logic [NPROC-1:0] wr_o,
    output logic [NPROC-1:0] ww_o,
    input  logic             commit_i,
    output logic             cas_req_o,
    output logic [PID_W-1:0] cas_pid_o,
    input  logic             cas_ack_i,
    output logic             done_o
);

    logic [NPROC-1:0] abort_mask;
    logic             walk_busy;

    xconf_tables #(.NPROC(NPROC), .LOCAL_ID(LOCAL_ID)) tables_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .clr_i         (clr_i),
        .resp_valid_i  (resp_valid_i),
        .resp_pid_i    (resp_pid_i),
        .resp_kind_i   (resp_kind_i),
        .snoop_valid_i (snoop_valid_i),
        .snoop_pid_i   (snoop_pid_i),
        .snoop_kind_i  (snoop_kind_i),
        .rw_o          (rw_o),
        .wr_o          (wr_o),
        .ww_o          (ww_o)
    );

    // Peers to abort: union of write-read and write-write
    assign abort_mask = wr_o | ww_o;

    xconf_walker #(.NPROC(NPROC)) walker_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .commit_i     (commit_i),
        .abort_mask_i (abort_mask),
        .cas_ack_i    (cas_ack_i),
        .cas_req_o    (cas_req_o),
        .cas_pid_o    (cas_pid_o),
        .done_o       (done_o),
        .busy_o       (walk_busy)
    );

endmodule

// File: rtl/xconf_chk.sv
module xconf_chk #(
    parameter int unsigned NPROC    = 8,
    parameter int unsigned LOCAL_ID = 0,
    localparam int unsigned PID_W   = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             clr_i,
    input logic             commit_i,
    input logic             busy_i,
    input logic [NPROC-1:0] rw_i,
    input logic [NPROC-1:0] wr_i,
    input logic [NPROC-1:0] ww_i,
    input logic             cas_req_i,
    input logic [PID_W-1:0] cas_pid_i,
    input logic             cas_ack_i,
    input logic             done_i
);

    p_local_never_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rw_i[LOCAL_ID] && !wr_i[LOCAL_ID] && !ww_i[LOCAL_ID]);

    p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> (((rw_i & $past(rw_i)) == $past(rw_i)) &&
                    ((wr_i & $past(wr_i)) == $past(wr_i)) &&
                    ((ww_i & $past(ww_i)) == $past(ww_i))));

    p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> ((rw_i | wr_i | ww_i) == '0));

    p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cas_req_i && !cas_ack_i) |=> (cas_req_i && $stable(cas_pid_i)));

    p_empty_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_i && !busy_i && ((wr_i | ww_i) == '0)) |=> done_i);

    p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> !done_i);

    p_done_no_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> !cas_req_i);

endmodule

bind xconf_table xconf_chk #(.NPROC(NPROC), .LOCAL_ID(LOCAL_ID)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .commit_i  (commit_i),
    .busy_i    (walk_busy),
    .rw_i      (rw_o),
    .wr_i      (wr_o),
    .ww_i      (ww_o),
    .cas_req_i (cas_req_o),
    .cas_pid_i (cas_pid_o),
    .cas_ack_i (cas_ack_i),
    .done_i    (done_o)
);

// File: tb/xconf_table_tb_top.sv
`timescale 1ns/1ps
module xconf_table_tb_top;

    localparam int NPROC = 8;
    localparam int PID_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr = 1'b0;
    logic             resp_valid = 1'b0;
    logic [PID_W-1:0] resp_pid = '0;
    logic [1:0]       resp_kind = '0;
    logic             snoop_valid = 1'b0;
    logic [PID_W-1:0] snoop_pid = '0;
    logic [1:0]       snoop_kind = '0;
    logic [NPROC-1:0] rw, wr, ww;
    logic             commit = 1'b0;
    logic             cas_req;
    logic [PID_W-1:0] cas_pid;
    logic             cas_ack = 1'b0;
    logic             done;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    xconf_table #(.NPROC(NPROC), .LOCAL_ID(0)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
        .resp_valid_i(resp_valid), .resp_pid_i(resp_pid), .resp_kind_i(resp_kind),
        .snoop_valid_i(snoop_valid), .snoop_pid_i(snoop_pid), .snoop_kind_i(snoop_kind),
        .rw_o(rw), .wr_o(wr), .ww_o(ww),
        .commit_i(commit), .cas_req_o(cas_req), .cas_pid_o(cas_pid),
        .cas_ack_i(cas_ack), .done_o(done)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tables_are(string tag, int e_rw, int e_wr, int e_ww);
        chk({tag, " rw"}, int'(rw), e_rw);
        chk({tag, " wr"}, int'(wr), e_wr);
        chk({tag, " ww"}, int'(ww), e_ww);
    endtask

    task automatic send_resp(int pid, int kind);
        resp_valid = 1'b1; resp_pid = PID_W'(pid); resp_kind = 2'(kind);
        tick();
        resp_valid = 1'b0;
    endtask

    task automatic do_clear();
        clr = 1'b1;
        tick();
        clr = 1'b0;
    endtask

    // Expect requests for every bit of mask, ascending; peer p held (p % 3) cycles
    task automatic walk(string tag, int mask);
        commit = 1'b1;
        tick();
        commit = 1'b0;
        for (int p = 0; p < NPROC; p++) begin
            if (mask[p]) begin
                for (int h = 0; h < (p % 3); h++) begin
                    chk({tag, " R6 held req"}, int'(cas_req), 1);
                    chk({tag, " R6 held pid"}, int'(cas_pid), p);
                    tick();
                end
                chk({tag, " R5 req"}, int'(cas_req), 1);
                chk({tag, " R5 pid order"}, int'(cas_pid), p);
                chk({tag, " R8 no early done"}, int'(done), 0);
                cas_ack = 1'b1;
                tick();
                cas_ack = 1'b0;
            end
        end
        chk({tag, " R8 done"}, int'(done), 1);
        chk({tag, " R8 req low at done"}, int'(cas_req), 0);
        tick();
        chk({tag, " R8 done pulse"}, int'(done), 0);
        chk({tag, " R9 no rewalk"}, int'(cas_req), 0);
    endtask

    task automatic t_reset();
        tables_are("R4 reset", 0, 0, 0);
        chk("R8 reset done", int'(done), 0);
        chk("R6 reset req", int'(cas_req), 0);
    endtask

    task automatic t_resp_kinds();
        send_resp(3, 1);
        tables_are("R1 rw set", 'h08, 0, 0);
        send_resp(4, 2);
        tables_are("R1 wr set", 'h08, 'h10, 0);
        send_resp(6, 3);
        tables_are("R1 ww set", 'h08, 'h10, 'h40);
        send_resp(5, 0);
        tables_are("R1 kind none", 'h08, 'h10, 'h40);
        do_clear();
        tables_are("R4 clear", 0, 0, 0);
    endtask

    task automatic t_snoop_both();
        resp_valid = 1'b1; resp_pid = 3'd1; resp_kind = 2'd2;
        snoop_valid = 1'b1; snoop_pid = 3'd2; snoop_kind = 2'd3;
        tick();
        resp_valid = 1'b0; snoop_valid = 1'b0;
        tables_are("R2 same cycle", 0, 'h02, 'h04);
        snoop_valid = 1'b1; snoop_pid = 3'd7; snoop_kind = 2'd1;
        tick();
        snoop_valid = 1'b0;
        tables_are("R3 sticky", 'h80, 'h02, 'h04);
        do_clear();
    endtask

    task automatic t_local();
        resp_valid = 1'b1; resp_pid = 3'd0; resp_kind = 2'd3;
        snoop_valid = 1'b1; snoop_pid = 3'd0; snoop_kind = 2'd1;
        tick();
        resp_valid = 1'b0; snoop_valid = 1'b0;
        tables_are("R3 local ignored", 0, 0, 0);
    endtask

    task automatic t_clear_prio();
        send_resp(2, 2);
        clr = 1'b1;
        resp_valid = 1'b1; resp_pid = 3'd6; resp_kind = 2'd3;
        tick();
        clr = 1'b0; resp_valid = 1'b0;
        tables_are("R4 clear wins", 0, 0, 0);
    endtask

    task automatic t_walk_mixed();
        send_resp(2, 2);
        send_resp(5, 2);
        send_resp(5, 3);
        send_resp(7, 3);
        send_resp(3, 1);
        walk("R7 overlap", 'hA4);
        tables_are("R9 tables kept", 'h08, 'h24, 'hA0);
        do_clear();
    endtask

    task automatic t_walk_empty();
        send_resp(4, 1);
        commit = 1'b1;
        tick();
        commit = 1'b0;
        chk("R8 empty done", int'(done), 1);
        chk("R5 rw only no req", int'(cas_req), 0);
        tick();
        chk("R8 empty pulse", int'(done), 0);
        do_clear();
    endtask

    task automatic t_commit_busy();
        send_resp(1, 3);
        commit = 1'b1;
        tick();
        chk("R5 first req", int'(cas_req), 1);
        chk("R5 first pid", int'(cas_pid), 1);
        tick();
        commit = 1'b0;
        chk("R9 req held", int'(cas_req), 1);
        cas_ack = 1'b1;
        tick();
        cas_ack = 1'b0;
        chk("R8 done after ack", int'(done), 1);
        tick();
        chk("R9 second commit ignored", int'(cas_req), 0);
        chk("R9 no second done", int'(done), 0);
        do_clear();
    endtask

    task automatic t_walk_full();
        for (int p = 1; p < NPROC; p++) send_resp(p, (p % 2 == 0) ? 2 : 3);
        walk("R5 all peers", 'hFE);
        do_clear();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_resp_kinds();
        t_snoop_both();
        t_local();
        t_clear_prio();
        t_walk_mixed();
        t_walk_empty();
        t_commit_busy();
        t_walk_full();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule